// File: doc/BRIEF.md
# Test Vector Step Sequencer

This block walks a small table of step entries and turns it into the address stream for a vector store and a record store. Each entry gives a first vector address, a vector count, a clocks-per-vector count, a record mode, timing values (base period, phase, window) and a control opcode with its jump target, loop count and trigger select. While the block runs, every system clock enable advances the position within the current vector. When the last vector of a step is done, the opcode picks the next step.

The table is written through a simple write port while the block is idle. A start pulse begins execution at step 0. Conditional opcodes look at the cumulative error input and at a bank of trigger inputs. The block counts the enables on which the error input is high. It runs until a halt opcode takes effect. The timing fields and the record mode of the current step are presented on outputs for the phase and window generators and for the capture logic.

Top module: `step_sequencer`

## Requirements
- R1: While reset is asserted, and after it is released, busy is 0 and step_idx, vec_addr, rec_addr and err_count are all 0.
- R2: A table word is written on tbl_we. Its fields run from MSB to LSB as: opcode (3), target (4), loop count (4), trigger select (2), record mode (1), clocks-per-vector minus one (3), vector count minus one (4), first vector address (8), period (8), phase (6), window (6). period, phase, window and rec_mode always show the fields of the entry at step_idx.
- R3: A start pulse while idle sets busy on the next edge. That edge also sets step_idx to 0, loads vec_addr from entry 0's first address and clears rec_addr and err_count. A start pulse while busy is ignored.
- R4: Each vector address is held for (clocks-per-vector minus one) + 1 enables. A cycle with sys_en low changes no output.
- R5: A step presents (vector count minus one) + 1 consecutive vector addresses, starting at its first address. After the last one, the next step's first address is loaded on the same edge.
- R6: rec_addr increases by one on each enable that completes a vector, and it keeps counting across steps.
- R7: Opcode 0 (and the unused code 7) goes to step_idx+1, wrapping modulo 16. Opcode 1 goes unconditionally to the target.
- R8: Opcode 2 goes to the target if err_in was high on any enable of the step, including the last one. Otherwise it goes to the next step.
- R9: Opcode 3 with loop count N jumps to the target N times and then falls through. This makes N+1 passes over the looped steps.
- R10: Opcode 4 clears busy after the step's last vector. After that, addresses, step_idx and err_count stay frozen.
- R11: Opcode 5 goes to the target if trig_in[trigger select] is high on the step's last enable. Otherwise it goes to the next step.
- R12: Opcode 6 halts as opcode 4 does if err_in was high on any enable of the step. Otherwise it goes to the next step.
- R13: err_count increments on every enable with err_in high while busy, and it saturates at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Step table write strobe |
| tbl_addr | input | 4 | Step table write index |
| tbl_wdata | input | 49 | Step table write word |
| start | input | 1 | Begin execution at step 0 |
| sys_en | input | 1 | System clock enable |
| err_in | input | 1 | Cumulative error input |
| trig_in | input | 4 | Trigger inputs for conditional jumps |
| busy | output | 1 | Sequence running |
| step_idx | output | 4 | Current step |
| vec_addr | output | 8 | Vector store address |
| rec_addr | output | 10 | Record store address |
| rec_mode | output | 1 | Record mode of current step |
| period | output | 8 | Base period of current step |
| phase | output | 6 | Phase value of current step |
| window | output | 6 | Window value of current step |
| err_count | output | 8 | Count of enables with error |

## Verification
The state registers move on the clock edge where sys_en, start or a table write is seen. The addresses, the step index, busy and the error count are therefore due one edge after the enable that causes them. The timing fields and rec_mode follow step_idx in the same cycle. The bench drives each input on a falling edge and moves a reference model forward at the next rising edge. It compares every output at the following falling edge, so each result is sampled exactly one edge after its stimulus. Hand-computed final steps and address totals for each opcode program add a check that does not depend on the model.

// File: rtl/seqr_pkg.sv
package seqr_pkg;
  localparam int STEP_AW = 4;
  localparam int VA_W    = 8;
  localparam int RA_W    = 10;
  localparam int VC_W    = 4;
  localparam int CPV_W   = 3;
  localparam int PER_W   = 8;
  localparam int TIM_W   = 6;
  localparam int LC_W    = 4;
  localparam int TRIG_N  = 4;
  localparam int TS_W    = $clog2(TRIG_N);
  localparam int EC_W    = 8;
  localparam int DEPTH   = 1 << STEP_AW;

  typedef enum logic [2:0] {
    OP_NEXT  = 3'd0,
    OP_JUMP  = 3'd1,
    OP_JERR  = 3'd2,
    OP_LOOP  = 3'd3,
    OP_HALT  = 3'd4,
    OP_JTRIG = 3'd5,
    OP_HERR  = 3'd6
  } op_e;

  typedef struct packed {
    op_e                op;
    logic [STEP_AW-1:0] target;
    logic [LC_W-1:0]    loop_n;
    logic [TS_W-1:0]    trig_sel;
    logic               rec_mode;
    logic [CPV_W-1:0]   cpv_m1;
    logic [VC_W-1:0]    vcnt_m1;
    logic [VA_W-1:0]    vbase;
    logic [PER_W-1:0]   period;
    logic [TIM_W-1:0]   phase;
    logic [TIM_W-1:0]   window;
  } step_t;

  localparam int STEP_W = $bits(step_t);
endpackage

// File: rtl/seqr_step_table.sv
module seqr_step_table
  import seqr_pkg::*;
(
  input  logic               clk,
  input  logic               we,
  input  logic [STEP_AW-1:0] waddr,
  input  step_t              wdata,
  input  logic [STEP_AW-1:0] raddr,
  input  logic [STEP_AW-1:0] naddr,
  output step_t              rd,
  output logic [VA_W-1:0]    nbase
);
  step_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rd    = mem[raddr];
  assign nbase = mem[naddr].vbase;
endmodule

// File: rtl/seqr_vec_counter.sv
module seqr_vec_counter
  import seqr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clr,
  input  logic             enter,
  input  logic [VA_W-1:0]  enter_base,
  input  logic [CPV_W-1:0] cpv_m1,
  input  logic [VC_W-1:0]  vcnt_m1,
  output logic [VA_W-1:0]  vec_addr,
  output logic [RA_W-1:0]  rec_addr,
  output logic             step_done
);
  logic [CPV_W-1:0] cc_q, cc_d;
  logic [VC_W-1:0]  vi_q, vi_d;
  logic [VA_W-1:0]  va_d;
  logic [RA_W-1:0]  ra_d;
  logic             cpv_last, vec_last, vdone;

  always_comb begin
    cpv_last  = (cc_q == cpv_m1);
    vec_last  = (vi_q == vcnt_m1);
    vdone     = adv & cpv_last;
    step_done = vdone & vec_last;
    cc_d = cc_q;
    vi_d = vi_q;
    va_d = vec_addr;
    if (enter) begin
      cc_d = '0;
      vi_d = '0;
      va_d = enter_base;
    end else if (adv) begin
      if (cpv_last) begin
        cc_d = '0;
        if (!vec_last) begin
          vi_d = vi_q + 1'b1;
          va_d = vec_addr + 1'b1;
        end
      end else begin
        cc_d = cc_q + 1'b1;
      end
    end
    ra_d = rec_addr;
    if (clr)        ra_d = '0;
    else if (vdone) ra_d = rec_addr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_q     <= '0;
      vi_q     <= '0;
      vec_addr <= '0;
      rec_addr <= '0;
    end else begin
      cc_q     <= cc_d;
      vi_q     <= vi_d;
      vec_addr <= va_d;
      rec_addr <= ra_d;
    end
  end

  assert_hold_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !cpv_last && !enter) |=> $stable(vec_addr));

  assert_vector_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cpv_last && !vec_last && !enter) |=> (vec_addr == VA_W'($past(vec_addr) + 1'b1)));

  assert_record_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cpv_last && !clr) |=> (rec_addr == RA_W'($past(rec_addr) + 1'b1)));

  assert_idle_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !enter && !clr) |=> ($stable(vec_addr) && $stable(rec_addr)));
endmodule

// File: rtl/seqr_ctrl.sv
module seqr_ctrl
  import seqr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               sys_en,
  input  logic               err_in,
  input  logic [TRIG_N-1:0]  trig_in,
  input  op_e                op,
  input  logic [STEP_AW-1:0] target,
  input  logic [LC_W-1:0]    loop_n,
  input  logic [TS_W-1:0]    trig_sel,
  input  logic               step_done,
  output logic               busy,
  output logic               launch,
  output logic               adv,
  output logic               enter,
  output logic [STEP_AW-1:0] cur_step,
  output logic [STEP_AW-1:0] nxt_step,
  output logic [EC_W-1:0]    err_count
);
  logic               err_seen, err_seen_d, err_now;
  logic               busy_d, jump, halt;
  logic               loop_act, loop_act_d;
  logic [LC_W-1:0]    loop_cnt, loop_cnt_d, loop_rem;
  logic [STEP_AW-1:0] step_d;
  logic [EC_W-1:0]    ec_d;

  always_comb begin
    adv      = busy & sys_en;
    launch   = start & ~busy;
    err_now  = err_seen | err_in;
    loop_rem = loop_act ? loop_cnt : loop_n;
    jump = 1'b0;
    halt = 1'b0;
    case (op)
      OP_JUMP:  jump = 1'b1;
      OP_JERR:  jump = err_now;
      OP_LOOP:  jump = (loop_rem != '0);
      OP_HALT:  halt = 1'b1;
      OP_JTRIG: jump = trig_in[trig_sel];
      OP_HERR:  halt = err_now;
      default:  jump = 1'b0;
    endcase
    enter    = launch | (step_done & ~halt);
    nxt_step = launch ? '0 : (jump ? target : cur_step + 1'b1);
    step_d   = enter ? nxt_step : cur_step;

    busy_d = busy;
    if (launch)                 busy_d = 1'b1;
    else if (step_done && halt) busy_d = 1'b0;

    err_seen_d = err_seen;
    if (enter)              err_seen_d = 1'b0;
    else if (adv && err_in) err_seen_d = 1'b1;

    ec_d = err_count;
    if (launch)                                  ec_d = '0;
    else if (adv && err_in && err_count != '1)   ec_d = err_count + 1'b1;

    loop_act_d = loop_act;
    loop_cnt_d = loop_cnt;
    if (launch) begin
      loop_act_d = 1'b0;
    end else if (step_done && op == OP_LOOP) begin
      loop_act_d = (loop_rem != '0);
      if (loop_rem != '0) loop_cnt_d = loop_rem - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cur_step  <= '0;
      err_seen  <= 1'b0;
      err_count <= '0;
      loop_act  <= 1'b0;
      loop_cnt  <= '0;
    end else begin
      busy      <= busy_d;
      cur_step  <= step_d;
      err_seen  <= err_seen_d;
      err_count <= ec_d;
      loop_act  <= loop_act_d;
      loop_cnt  <= loop_cnt_d;
    end
  end

  assert_start_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && cur_step == '0 && err_count == '0));

  assert_no_enable_no_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sys_en) |=> (busy && $stable(cur_step) && $stable(err_count)));

  assert_halt_clears_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && op == OP_HALT) |=> !busy);

  assert_idle_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> (!busy && $stable(cur_step) && $stable(err_count)));

  assert_err_count_monotonic_R13: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (err_count >= $past(err_count)));
endmodule

// File: rtl/step_sequencer.sv
module step_sequencer
  import seqr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tbl_we,
  input  logic [STEP_AW-1:0] tbl_addr,
  input  logic [STEP_W-1:0]  tbl_wdata,
  input  logic               start,
  input  logic               sys_en,
  input  logic               err_in,
  input  logic [TRIG_N-1:0]  trig_in,
  output logic               busy,
  output logic [STEP_AW-1:0] step_idx,
  output logic [VA_W-1:0]    vec_addr,
  output logic [RA_W-1:0]    rec_addr,
  output logic               rec_mode,
  output logic [PER_W-1:0]   period,
  output logic [TIM_W-1:0]   phase,
  output logic [TIM_W-1:0]   window,
  output logic [EC_W-1:0]    err_count
);
  logic [1:0]         rst_pipe;
  logic               rst_n_s;
  logic               launch, adv, enter, step_done;
  logic [STEP_AW-1:0] nxt_step;
  logic [VA_W-1:0]    nbase;
  step_t              cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  seqr_step_table u_table (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wdata (step_t'(tbl_wdata)),
    .raddr (step_idx),
    .naddr (nxt_step),
    .rd    (cur),
    .nbase (nbase)
  );

  seqr_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start     (start),
    .sys_en    (sys_en),
    .err_in    (err_in),
    .trig_in   (trig_in),
    .op        (cur.op),
    .target    (cur.target),
    .loop_n    (cur.loop_n),
    .trig_sel  (cur.trig_sel),
    .step_done (step_done),
    .busy      (busy),
    .launch    (launch),
    .adv       (adv),
    .enter     (enter),
    .cur_step  (step_idx),
    .nxt_step  (nxt_step),
    .err_count (err_count)
  );

  seqr_vec_counter u_vec (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .adv        (adv),
    .clr        (launch),
    .enter      (enter),
    .enter_base (nbase),
    .cpv_m1     (cur.cpv_m1),
    .vcnt_m1    (cur.vcnt_m1),
    .vec_addr   (vec_addr),
    .rec_addr   (rec_addr),
    .step_done  (step_done)
  );

  assign rec_mode = cur.rec_mode;
  assign period   = cur.period;
  assign phase    = cur.phase;
  assign window   = cur.window;
endmodule

// File: tb/step_sequencer_bench.sv
module step_sequencer_bench;
  import seqr_pkg::*;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               tbl_we;
  logic [STEP_AW-1:0] tbl_addr;
  logic [STEP_W-1:0]  tbl_wdata;
  logic               start, sys_en, err_in;
  logic [TRIG_N-1:0]  trig_in;
  logic               busy, rec_mode;
  logic [STEP_AW-1:0] step_idx;
  logic [VA_W-1:0]    vec_addr;
  logic [RA_W-1:0]    rec_addr;
  logic [PER_W-1:0]   period;
  logic [TIM_W-1:0]   phase, window;
  logic [EC_W-1:0]    err_count;

  int n_chk = 0;
  int n_fail = 0;

  // bench copy of the table, unpacked
  int t_op[16], t_tg[16], t_ln[16], t_ts[16], t_rm[16];
  int t_cpv[16], t_vc[16], t_base[16], t_per[16], t_ph[16], t_win[16];

  // reference state
  bit         m_busy, m_la, m_es;
  logic [3:0] m_step, m_lc;
  logic [7:0] m_vec, m_ec;
  logic [9:0] m_rec;
  int         m_cc, m_vi;

  always #2.5 clk = ~clk;

  step_sequencer u_step_sequencer (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .start(start), .sys_en(sys_en), .err_in(err_in),
    .trig_in(trig_in), .busy(busy), .step_idx(step_idx), .vec_addr(vec_addr),
    .rec_addr(rec_addr), .rec_mode(rec_mode), .period(period), .phase(phase),
    .window(window), .err_count(err_count)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic wr(input int idx, input int op, input int tg, input int ln, input int ts,
                    input int cpv, input int vc, input int base);
    int per, ph, win, rm;
    per = (idx * 13 + op * 5 + base) % 256;
    ph  = (idx * 3 + 1) % 64;
    win = (idx * 7 + vc + 2) % 64;
    rm  = (idx + op) % 2;
    t_op[idx] = op;  t_tg[idx] = tg;   t_ln[idx] = ln;   t_ts[idx] = ts;   t_rm[idx] = rm;
    t_cpv[idx] = cpv; t_vc[idx] = vc;  t_base[idx] = base;
    t_per[idx] = per; t_ph[idx] = ph;  t_win[idx] = win;
    tbl_we    = 1'b1;
    tbl_addr  = 4'(idx);
    tbl_wdata = {3'(op), 4'(tg), 4'(ln), 2'(ts), 1'(rm), 3'(cpv), 4'(vc), 8'(base),
                 8'(per), 6'(ph), 6'(win)};
    @(posedge clk);
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic step_end(input logic [3:0] tr);
    logic [3:0] nx;
    int rem;
    bit hl;
    nx = m_step + 4'd1;
    hl = 1'b0;
    case (t_op[m_step])
      1: nx = 4'(t_tg[m_step]);
      2: if (m_es) nx = 4'(t_tg[m_step]);
      3: begin
        rem = m_la ? int'(m_lc) : t_ln[m_step];
        if (rem > 0) begin nx = 4'(t_tg[m_step]); m_lc = 4'(rem - 1); m_la = 1'b1; end
        else m_la = 1'b0;
      end
      4: hl = 1'b1;
      5: if (tr[t_ts[m_step]]) nx = 4'(t_tg[m_step]);
      6: if (m_es) hl = 1'b1;
      default: ;
    endcase
    if (hl) m_busy = 1'b0;
    else begin
      m_step = nx; m_vec = 8'(t_base[nx]); m_vi = 0; m_cc = 0; m_es = 1'b0;
    end
  endtask

  task automatic model_edge(input bit s, input bit en, input bit er, input logic [3:0] tr);
    if (!m_busy) begin
      if (s) begin
        m_busy = 1'b1; m_step = 4'd0; m_vec = 8'(t_base[0]); m_vi = 0; m_cc = 0;
        m_rec = '0; m_ec = '0; m_la = 1'b0; m_es = 1'b0;
      end
    end else if (en) begin
      if (er) begin
        m_es = 1'b1;
        if (m_ec != 8'hFF) m_ec = m_ec + 8'd1;
      end
      if (m_cc == t_cpv[m_step]) begin
        m_cc = 0;
        m_rec = m_rec + 10'd1;
        if (m_vi == t_vc[m_step]) step_end(tr);
        else begin m_vi++; m_vec = m_vec + 8'd1; end
      end else m_cc++;
    end
  endtask

  task automatic compare();
    chk("R10", "busy", int'(busy), int'(m_busy));
    chk("R7", "step_idx", int'(step_idx), int'(m_step));
    chk("R4 R5", "vec_addr", int'(vec_addr), int'(m_vec));
    chk("R6", "rec_addr", int'(rec_addr), int'(m_rec));
    chk("R13", "err_count", int'(err_count), int'(m_ec));
    chk("R2", "period", int'(period), t_per[m_step]);
    chk("R2", "phase", int'(phase), t_ph[m_step]);
    chk("R2", "window", int'(window), t_win[m_step]);
    chk("R2", "rec_mode", int'(rec_mode), t_rm[m_step]);
  endtask

  // one clock: inputs set at the falling edge, model follows the rising edge,
  // outputs compared at the next falling edge
  task automatic tick(input bit s, input bit en, input bit er, input logic [3:0] tr);
    start = s; sys_en = en; err_in = er; trig_in = tr;
    @(posedge clk);
    model_edge(s, en, er, tr);
    @(negedge clk);
    compare();
  endtask

  // sc selects the enable/error/trigger pattern of a scenario
  task automatic run(input int sc);
    bit en, er;
    logic [3:0] tr;
    tick(1'b1, 1'b0, 1'b0, 4'd0);
    for (int i = 0; i < 400; i++) begin
      en = 1'b1; er = 1'b0; tr = 4'd0;
      case (sc)
        1: en = (i % 3 != 2);
        2: en = (i % 2 == 0);
        3: er = (i == 1);
        4: begin tr = 4'b0100; er = (i == 2); end
        default: ;
      endcase
      tick((sc == 1) && (i == 5), en, er, tr);
      if (!m_busy && !busy) break;
    end
    tick(1'b0, 1'b1, 1'b1, 4'hF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tbl_we = 1'b0; tbl_addr = '0; tbl_wdata = '0;
    start = 1'b0; sys_en = 1'b0; err_in = 1'b0; trig_in = '0;
    m_busy = 1'b0; m_step = '0; m_vec = '0; m_rec = '0; m_ec = '0;
    m_la = 1'b0; m_lc = '0; m_es = 1'b0; m_cc = 0; m_vi = 0;
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "step in reset", int'(step_idx), 0);
    chk("R1", "vec in reset", int'(vec_addr), 0);
    chk("R1", "rec in reset", int'(rec_addr), 0);
    chk("R1", "err in reset", int'(err_count), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "step after reset", int'(step_idx), 0);
    chk("R1", "rec after reset", int'(rec_addr), 0);
    for (int k = 0; k < 16; k++) wr(k, 4, 0, 0, 0, 0, 0, k * 16);
    compare();

    // R7 R4 R5 R6 R3: next, jump, unused code, halt; enable gaps; start while busy
    wr(0, 0, 0, 0, 0, 1, 2, 10);
    wr(1, 1, 3, 0, 0, 0, 0, 40);
    wr(2, 4, 0, 0, 0, 0, 0, 90);
    wr(3, 7, 0, 0, 0, 2, 1, 100);
    wr(4, 4, 0, 0, 0, 0, 0, 200);
    run(1);
    chk("R7", "final step of jump program", int'(step_idx), 4);
    chk("R3", "records with start ignored", int'(rec_addr), 7);
    chk("R10", "halted", int'(busy), 0);

    // R9: loop count 2 gives three passes
    wr(0, 0, 0, 0, 0, 0, 1, 0);
    wr(1, 3, 0, 2, 0, 1, 0, 20);
    wr(2, 4, 0, 0, 0, 0, 0, 30);
    run(2);
    chk("R9", "final step of loop program", int'(step_idx), 2);
    chk("R9", "records after loop", int'(rec_addr), 10);

    // R8 R13: error inside step 0 jumps, clean step 2 falls through
    wr(0, 2, 2, 0, 0, 0, 3, 5);
    wr(1, 4, 0, 0, 0, 0, 0, 50);
    wr(2, 2, 4, 0, 0, 0, 0, 60);
    wr(3, 4, 0, 0, 0, 0, 0, 77);
    run(3);
    chk("R8", "final step of error jump", int'(step_idx), 3);
    chk("R13", "error count", int'(err_count), 1);

    // R11 R12: trigger jump, then halt on error
    wr(0, 5, 3, 0, 2, 0, 0, 8);
    wr(1, 4, 0, 0, 0, 0, 0, 18);
    wr(3, 6, 0, 0, 0, 0, 1, 33);
    wr(4, 4, 0, 0, 0, 0, 0, 44);
    run(4);
    chk("R11", "trigger jump taken", int'(step_idx), 3);
    chk("R12", "halt on error", int'(busy), 0);
    chk("R12", "vec frozen at halt", int'(vec_addr), 34);

    // R11 R12: trigger low and no error
    run(0);
    chk("R11", "trigger jump not taken", int'(step_idx), 1);
    chk("R12", "records without error halt", int'(rec_addr), 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule